// File: doc/BRIEF.md
# Coprocessor Bank-Switching Memory Mapper

This block sits between a coprocessor CPU and its memory devices. It takes each 16-bit CPU memory address and turns it into a 19-bit physical address over 512 KB of RAM, along with one select for the RAM and one for the boot ROM. A single 8-bit control register sets the mapping. While its map-enable bit is clear, the block is in boot mode: reads below the common region go to the boot ROM, and writes to that region land in RAM bank 0. While the map-enable bit is set, the lower 48 KB of the CPU space maps into one of eight 64 KB RAM banks. The top 16 KB of the CPU space always reaches one fixed, shared 16 KB RAM segment.

The CPU writes the control register through offset 3 of its I/O window. The same write also sets two user LED outputs, which are active low. All outputs are registered. Each memory access therefore produces its selects and physical address one clock after it is presented. Reset clears the register, which leaves the block in boot mode with both LEDs lit.

Top module: `cop_bank_mapper`

## Requirements
- R1: After reset the control register is zero, so the block is in boot mode and led_n is 2'b00 (both LEDs lit). While reset is held, both selects are low.
- R2: The control register loads wdata only on a cycle with io_wr high and io_off equal to 3. An io_wr with any other offset leaves the mapping and the LEDs unchanged.
- R3: An access with cpu_addr[15:14] = 2'b11 asserts ram_sel and gives phys_addr = 0x7C000 + cpu_addr[13:0]. This holds in every mode.
- R4: With control bit 3 = 1, an access below 0xC000 asserts ram_sel and gives phys_addr = {ctrl[2:0], cpu_addr}. So 0x08 selects bank 0 and 0x0F selects bank 7.
- R5: With control bit 3 = 0, a read (mem_wr low) below 0xC000 asserts rom_sel, leaves ram_sel low, and gives phys_addr = {3'b000, cpu_addr}.
- R6: With control bit 3 = 0, a write (mem_wr high) below 0xC000 asserts ram_sel, leaves rom_sel low, and gives phys_addr = {3'b000, cpu_addr}, which is in bank 0.
- R7: With control bit 3 = 0, control bits 2:0 have no effect on the mapping.
- R8: When mreq is low, ram_sel and rom_sel are both low on the next cycle.
- R9: led_n equals control bits 7:6 from the cycle after the register write. Control bits 5:4 do not change the mapping.
- R10: The selects and phys_addr reflect the inputs of the previous clock edge. A control write is used by every access presented from the following cycle on.
- R11: ram_sel and rom_sel are never high together.
- R12: An access below 0xC000 never produces a RAM address inside the common segment 0x7C000 to 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU memory address |
| mreq | input | 1 | Memory access request |
| mem_wr | input | 1 | 1 = memory write, 0 = memory read |
| io_wr | input | 1 | I/O write strobe |
| io_off | input | 2 | Offset within the coprocessor I/O window |
| wdata | input | 8 | Data for control-register writes |
| phys_addr | output | 19 | Registered physical address |
| ram_sel | output | 1 | Registered RAM select |
| rom_sel | output | 1 | Registered boot-ROM select |
| led_n | output | 2 | User LEDs, 0 = lit |

## Verification
The hardest case to reach from the ports is boot mode with a non-canonical register value, such as bit 3 clear while bits 2:0 are non-zero. In that state a read and a write to the same lower address must split between the ROM and bank 0. The case is made worse by a control write on the cycle just before the access. To reach it, the bench writes a set of register values that includes 0x05, 0x35 and 0xC7, with canonical bank values in between. After each write it sweeps the whole CPU space, both reads and writes, starting on the very next cycle. It also sends writes to the other I/O offsets and then repeats the sweep, which shows at the outputs that those writes changed nothing.

// File: rtl/cop_mapper_pkg.sv
package cop_mapper_pkg;
  // Control register field positions (fixed by the mapping behaviour)
  localparam int unsigned CTRL_W       = 8;
  localparam int unsigned MAP_EN_BIT   = 3;
  localparam int unsigned LED_HI_BIT   = 7;
  localparam int unsigned LED_COUNT    = 2;

  typedef struct packed {
    logic ram;
    logic rom;
  } dev_sel_t;

  localparam dev_sel_t SEL_NONE = '{ram: 1'b0, rom: 1'b0};
endpackage

// File: rtl/cop_ctrl_reg.sv
module cop_ctrl_reg #(
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned OFF_W    = 2,
  parameter int unsigned CTRL_OFF = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [OFF_W-1:0]  io_off,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam logic [OFF_W-1:0] HIT_OFF = OFF_W'(CTRL_OFF);

  logic hit;
  assign hit = io_wr && (io_off == HIT_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (hit) begin
      ctrl_q <= wdata;
    end
  end
endmodule

// File: rtl/cop_addr_decode.sv
module cop_addr_decode
  import cop_mapper_pkg::*;
#(
  parameter int unsigned CPU_AW  = 16,
  parameter int unsigned BANK_W  = 3,
  parameter int unsigned HIGH_AW = 14
) (
  input  logic                     map_en,
  input  logic [BANK_W-1:0]        bank,
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic                     mreq,
  input  logic                     mem_wr,
  output logic [CPU_AW+BANK_W-1:0] phys_nx,
  output dev_sel_t                 sel_nx
);
  localparam int unsigned PHYS_AW = CPU_AW + BANK_W;
  localparam int unsigned TOP_W   = CPU_AW - HIGH_AW;
  localparam int unsigned SEG_W   = PHYS_AW - HIGH_AW;

  logic              in_high;
  logic [BANK_W-1:0] eff_bank;
  logic              rom_read;

  // common region: all address bits above the region size set
  assign in_high  = &cpu_addr[CPU_AW-1:HIGH_AW];
  // boot mode forces bank 0 regardless of the bank field
  assign eff_bank = map_en ? bank : '0;
  assign rom_read = !map_en && !mem_wr && !in_high;

  always_comb begin
    if (in_high) begin
      phys_nx = {{SEG_W{1'b1}}, cpu_addr[HIGH_AW-1:0]};
    end else begin
      phys_nx = {eff_bank, cpu_addr};
    end
  end

  always_comb begin
    sel_nx = SEL_NONE;
    if (mreq) begin
      sel_nx.rom = rom_read;
      sel_nx.ram = !rom_read;
    end
  end

  // keep the top-bit width visible for parameter sanity
  if (TOP_W == 0) begin : g_bad_cfg
    initial $error("HIGH_AW must be smaller than CPU_AW");
  end
endmodule

// File: rtl/cop_out_stage.sv
module cop_out_stage
  import cop_mapper_pkg::*;
#(
  parameter int unsigned PHYS_AW = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHYS_AW-1:0] phys_nx,
  input  dev_sel_t           sel_nx,
  output logic [PHYS_AW-1:0] phys_q,
  output dev_sel_t           sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phys_q <= '0;
      sel_q  <= SEL_NONE;
    end else begin
      phys_q <= phys_nx;
      sel_q  <= sel_nx;
    end
  end
endmodule

// File: rtl/cop_bank_mapper.sv
module cop_bank_mapper
  import cop_mapper_pkg::*;
#(
  parameter int unsigned CPU_AW   = 16,
  parameter int unsigned BANK_W   = 3,
  parameter int unsigned HIGH_AW  = 14,
  parameter int unsigned OFF_W    = 2,
  parameter int unsigned CTRL_OFF = 3,
  localparam int unsigned PHYS_AW = CPU_AW + BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CPU_AW-1:0]    cpu_addr,
  input  logic                 mreq,
  input  logic                 mem_wr,
  input  logic                 io_wr,
  input  logic [OFF_W-1:0]     io_off,
  input  logic [CTRL_W-1:0]    wdata,
  output logic [PHYS_AW-1:0]   phys_addr,
  output logic                 ram_sel,
  output logic                 rom_sel,
  output logic [LED_COUNT-1:0] led_n
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [PHYS_AW-1:0] phys_nx;
  dev_sel_t           sel_nx;
  dev_sel_t           sel_q;

  cop_ctrl_reg #(
    .CTRL_W  (CTRL_W),
    .OFF_W   (OFF_W),
    .CTRL_OFF(CTRL_OFF)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .io_wr (io_wr),
    .io_off(io_off),
    .wdata (wdata),
    .ctrl_q(ctrl_q)
  );

  cop_addr_decode #(
    .CPU_AW (CPU_AW),
    .BANK_W (BANK_W),
    .HIGH_AW(HIGH_AW)
  ) u_dec (
    .map_en  (ctrl_q[MAP_EN_BIT]),
    .bank    (ctrl_q[BANK_W-1:0]),
    .cpu_addr(cpu_addr),
    .mreq    (mreq),
    .mem_wr  (mem_wr),
    .phys_nx (phys_nx),
    .sel_nx  (sel_nx)
  );

  cop_out_stage #(
    .PHYS_AW(PHYS_AW)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .phys_nx(phys_nx),
    .sel_nx (sel_nx),
    .phys_q (phys_addr),
    .sel_q  (sel_q)
  );

  assign ram_sel = sel_q.ram;
  assign rom_sel = sel_q.rom;

  // LEDs come straight from the register's top bits
  for (genvar i = 0; i < LED_COUNT; i++) begin : g_led
    assign led_n[i] = ctrl_q[LED_HI_BIT - (LED_COUNT - 1) + i];
  end
endmodule

// File: rtl/cop_bank_mapper_chk.sv
module cop_bank_mapper_chk #(
  parameter int unsigned CPU_AW   = 16,
  parameter int unsigned BANK_W   = 3,
  parameter int unsigned HIGH_AW  = 14,
  parameter int unsigned OFF_W    = 2,
  parameter int unsigned CTRL_OFF = 3,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned LED_CNT  = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [CPU_AW-1:0]         cpu_addr,
  input logic                      mreq,
  input logic                      mem_wr,
  input logic                      io_wr,
  input logic [OFF_W-1:0]          io_off,
  input logic [CTRL_W-1:0]         wdata,
  input logic [CPU_AW+BANK_W-1:0]  phys_addr,
  input logic                      ram_sel,
  input logic                      rom_sel,
  input logic [LED_CNT-1:0]        led_n
);
  localparam int unsigned PHYS_AW = CPU_AW + BANK_W;
  localparam logic [OFF_W-1:0] HIT_OFF = OFF_W'(CTRL_OFF);

  logic in_high;
  logic phys_in_seg;
  assign in_high     = &cpu_addr[CPU_AW-1:HIGH_AW];
  assign phys_in_seg = &phys_addr[PHYS_AW-1:HIGH_AW];

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (led_n == '0 && !ram_sel && !rom_sel));

  assert_led_follow_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && io_wr && io_off == HIT_OFF)
      |-> (led_n == $past(wdata[CTRL_W-1 -: LED_CNT])));

  assert_high_common_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && mreq && in_high)
      |-> (ram_sel && !rom_sel && phys_in_seg
           && phys_addr[HIGH_AW-1:0] == $past(cpu_addr[HIGH_AW-1:0])));

  assert_rom_only_read_R5: assert property (@(posedge clk) disable iff (rst)
    rom_sel |-> $past(mreq && !mem_wr && !in_high));

  assert_idle_no_sel_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !mreq) |-> (!ram_sel && !rom_sel));

  assert_sel_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(ram_sel && rom_sel));

  assert_no_alias_R12: assert property (@(posedge clk) disable iff (rst)
    (ram_sel && phys_in_seg) |-> $past(in_high));

  assert_low_offset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && mreq && !in_high)
      |-> (phys_addr[CPU_AW-1:0] == $past(cpu_addr)));
endmodule

bind cop_bank_mapper cop_bank_mapper_chk #(
  .CPU_AW  (CPU_AW),
  .BANK_W  (BANK_W),
  .HIGH_AW (HIGH_AW),
  .OFF_W   (OFF_W),
  .CTRL_OFF(CTRL_OFF)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_addr (cpu_addr),
  .mreq     (mreq),
  .mem_wr   (mem_wr),
  .io_wr    (io_wr),
  .io_off   (io_off),
  .wdata    (wdata),
  .phys_addr(phys_addr),
  .ram_sel  (ram_sel),
  .rom_sel  (rom_sel),
  .led_n    (led_n)
);

// File: tb/cop_bank_mapper_tb.sv
module cop_bank_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        mreq = 1'b0;
  logic        mem_wr = 1'b0;
  logic        io_wr = 1'b0;
  logic [1:0]  io_off = '0;
  logic [7:0]  wdata = '0;
  logic [18:0] phys_addr;
  logic        ram_sel;
  logic        rom_sel;
  logic [1:0]  led_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model_ctrl = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_bank_mapper u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mreq(mreq), .mem_wr(mem_wr),
    .io_wr(io_wr), .io_off(io_off), .wdata(wdata),
    .phys_addr(phys_addr), .ram_sel(ram_sel), .rom_sel(rom_sel), .led_n(led_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // control write: drive after a falling edge, held across one rising edge
  task automatic wr_ctrl(input logic [1:0] off, input logic [7:0] val);
    @(negedge clk);
    mreq = 1'b0; io_wr = 1'b1; io_off = off; wdata = val;
    if (off == 2'd3) model_ctrl = val;
    @(negedge clk);
    io_wr = 1'b0;
    check("R9 led_n after write", {30'd0, led_n}, {30'd0, model_ctrl[7:6]});
  endtask

  // one access: outputs appear at the next rising edge, sampled on the falling edge
  task automatic access(input logic [15:0] a, input logic w, input logic req_on, input string tag);
    logic [18:0] e_phys;
    logic        e_ram, e_rom;
    cpu_addr = a; mem_wr = w; mreq = req_on;
    e_ram = 1'b0; e_rom = 1'b0; e_phys = '0;
    if (a >= 16'hC000) begin
      e_ram = 1'b1; e_phys = 19'h7C000 + {5'd0, a[13:0]};
    end else if (model_ctrl[3]) begin
      e_ram = 1'b1; e_phys = {model_ctrl[2:0], a};
    end else if (!w) begin
      e_rom = 1'b1; e_phys = {3'b000, a};
    end else begin
      e_ram = 1'b1; e_phys = {3'b000, a};
    end
    if (!req_on) begin e_ram = 1'b0; e_rom = 1'b0; end
    @(negedge clk);
    check(tag, {30'd0, ram_sel, rom_sel}, {30'd0, e_ram, e_rom});
    if (req_on) check(tag, {13'd0, phys_addr}, {13'd0, e_phys});
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 64; i++) begin
      access(16'(i * 1024 + (i % 7) * 37), i[0], 1'b1, tag);
    end
    access(16'h0000, 1'b0, 1'b1, tag);
    access(16'hBFFF, 1'b0, 1'b1, tag);
    access(16'hBFFF, 1'b1, 1'b1, tag);
    access(16'hC000, 1'b0, 1'b1, "R3 high base");
    access(16'hFFFF, 1'b1, 1'b1, "R3 high top");
    access(16'h1234, 1'b0, 1'b0, "R8 no request");
    for (int i = 0; i < 16; i++) begin
      access(16'(i * 4096 + 5), 1'b0, 1'b1, tag);
      access(16'(i * 4096 + 5), 1'b1, 1'b1, tag);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [7:0] vals [12];
    vals = '{8'h00, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F,
             8'h05, 8'h35, 8'hC7};
    mreq = 1'b1; cpu_addr = 16'h0100;
    repeat (3) @(negedge clk);
    // R1: selects stay low while reset is held, LEDs lit
    check("R1 sel in reset", {30'd0, ram_sel, rom_sel}, 32'd0);
    check("R1 leds in reset", {30'd0, led_n}, 32'd0);
    rst = 1'b0;
    // R1/R5: boot mode after reset, low read goes to ROM
    access(16'h0100, 1'b0, 1'b1, "R1 R5 boot after reset");
    access(16'h0100, 1'b1, 1'b1, "R6 boot write bank0");
    sweep("R5 R6 boot mode");
    foreach (vals[k]) begin
      wr_ctrl(2'd3, vals[k]);
      // R10: access right after the write uses the new value
      access(16'h4321, 1'b0, 1'b1, "R10 next-cycle use");
      sweep(vals[k][3] ? "R4 bank mode" : "R7 boot non-canonical");
    end
    // R2: other offsets must not change mapping or LEDs
    wr_ctrl(2'd3, 8'h4B);
    for (int off = 0; off < 3; off++) begin
      wr_ctrl(2'(off), 8'h80);
      access(16'h2000, 1'b0, 1'b1, "R2 ignored offset");
    end
    sweep("R2 mapping kept");
    // R9: bits 5:4 do not change mapping
    wr_ctrl(2'd3, 8'h3E);
    sweep("R9 bits 5:4 ignored");
    // R1: reset again returns to boot mode
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; model_ctrl = 8'h00;
    check("R1 leds after reset", {30'd0, led_n}, 32'd0);
    access(16'h0010, 1'b0, 1'b1, "R1 boot after re-reset");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule